// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Step Unit

This block applies one event to one leaky integrate-and-fire neuron whose whole parameter and state record sits in a single 128-bit word. A shared neuron memory feeds it one word at a time. The block takes that word together with an event. The event is either a synaptic stimulus, carrying a 3-bit weight and an inhibitory/excitatory sign, or a time-reference tick that drives leakage. One clock later the block returns the rewritten word, a spike flag, and two learning flags for the synapses of the neuron's dendritic tree.

Besides the membrane potential, the record holds a 3-bit calcium trace and its own leak counter. The calcium trace rises with each spike and decays after a programmable number of ticks. The learning flags compare the updated membrane potential with a membrane threshold and compare calcium with three calcium thresholds. They tell the synapse logic whether a pre-synaptic spike should strengthen or weaken a weight. A disable bit silences firing only, so a disabled neuron keeps integrating and can still be watched.

Top module: `lif_neuron_step`

## Requirements
- R1: A result appears exactly one clock after `evValid` is sampled high. `outValid` is high for that single cycle. `spikeOut`, `sdspUp` and `sdspDown` are zero in every cycle without a result. Reset (`rstN` low) clears all outputs to zero.
- R2: Word layout: bit 0 model select (1 = this model), 7:1 leak amount, 8 leak enable, 16:9 firing threshold, 17 calcium enable, 25:18 membrane learning threshold, 28:26 / 31:29 / 34:32 calcium thresholds one/two/three, 39:35 calcium leak period, 77:70 membrane, 80:78 calcium, 85:81 calcium leak counter, 127 disable. Every bit outside the three state fields is returned unchanged.
- R3: A stimulus (`evKind` = 0) adds the weight to the membrane, saturating at 255, when `evInhib` = 0. It subtracts the weight, saturating at 0, when `evInhib` = 1.
- R4: After a stimulus, if the membrane is at or above the firing threshold and the neuron is enabled, `spikeOut` is 1 and the stored membrane is 0.
- R5: With the disable bit set, no spike is produced and the integrated membrane is kept even above threshold. Calcium, leak and flags still update.
- R6: A time-reference event (`evKind` = 1) lowers the membrane by the leak amount, flooring at 0, when leak enable is 1. Otherwise it leaves the membrane unchanged. A stimulus never applies leak.
- R7: With calcium enabled, each spike raises calcium by one, saturating at 7.
- R8: With calcium enabled and a non-zero period, each time-reference event advances the counter. When the advanced count reaches the period, the counter returns to 0 and calcium drops by one, flooring at 0. A zero period leaves counter and calcium untouched.
- R9: With calcium enable 0, calcium and its counter are never changed and both learning flags are 0.
- R10: `sdspUp` is 1 when calcium is enabled, the updated membrane is at or above the membrane learning threshold, and the updated calcium is at least threshold one and below threshold three.
- R11: `sdspDown` is 1 when calcium is enabled, the updated membrane is below the membrane learning threshold, and the updated calcium is at least threshold one and below threshold two. The two flags are never both 1.
- R12: With model select 0, the word is returned unchanged and no spike or flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Event present this cycle |
| evKind | input | 1 | 0 = synaptic stimulus, 1 = time reference |
| evInhib | input | 1 | Stimulus sign, 1 = inhibitory |
| evWeight | input | 3 | Stimulus weight |
| wordIn | input | 128 | Neuron record read from memory |
| outValid | output | 1 | Result valid pulse |
| wordOut | output | 128 | Updated neuron record |
| spikeOut | output | 1 | Neuron fired |
| sdspUp | output | 1 | Potentiation flag |
| sdspDown | output | 1 | Depression flag |

## Verification
The bench builds the block with its fixed 8-bit membrane, 3-bit calcium and 5-bit counter layout. With these widths both saturation edges (255 and 0, calcium 7 and 0) and the exact-threshold cases can be reached in a single event. Calcium leak periods of 0, 1 and 3 are tested, so the disabled, every-tick and multi-tick decay paths each appear. Filler patterns in the unused word bits show that the pass-through is exact.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int WORD_W = 128;
  localparam int VM_W   = 8;
  localparam int CA_W   = 3;
  localparam int CNT_W  = 5;
  localparam int WT_W   = 3;
  localparam int LEAK_W = 7;

  // record layout
  localparam int MODEL_BIT  = 0;
  localparam int LEAK_LSB   = 1;
  localparam int LEAKEN_BIT = LEAK_LSB + LEAK_W;
  localparam int THR_LSB    = LEAKEN_BIT + 1;
  localparam int CAEN_BIT   = THR_LSB + VM_W;
  localparam int THM_LSB    = CAEN_BIT + 1;
  localparam int CT1_LSB    = THM_LSB + VM_W;
  localparam int CT2_LSB    = CT1_LSB + CA_W;
  localparam int CT3_LSB    = CT2_LSB + CA_W;
  localparam int PER_LSB    = CT3_LSB + CA_W;
  localparam int VM_LSB     = 70;
  localparam int CA_LSB     = VM_LSB + VM_W;
  localparam int CNT_LSB    = CA_LSB + CA_W;
  localparam int STATE_MSB  = CNT_LSB + CNT_W - 1;
  localparam int DIS_BIT    = WORD_W - 1;

  typedef enum logic {EV_STIM = 1'b0, EV_TREF = 1'b1} ev_kind_e;

  typedef struct packed {
    logic load;     // an event is being applied
    logic integ;    // apply synaptic weight
    logic leakMem;  // apply membrane leak
    logic caTick;   // advance calcium leak counter
    logic caOn;     // calcium + learning flags live
    logic fireOk;   // spike generation allowed
  } step_ctrl_t;
endpackage

// File: rtl/lif_step_ctrl.sv
module lif_step_ctrl
  import lif_pkg::*;
(
  input  logic             evValid,
  input  logic             evKind,
  input  logic             modelSel,
  input  logic             leakEn,
  input  logic             caEn,
  input  logic             neurOff,
  input  logic [CNT_W-1:0] caPeriod,
  output step_ctrl_t       ctrl
);
  logic isTref;
  logic active;

  always_comb begin
    isTref       = (evKind == EV_TREF);
    active       = evValid && modelSel;
    ctrl.load    = evValid;
    ctrl.integ   = active && !isTref;
    ctrl.leakMem = active && isTref && leakEn;
    ctrl.caTick  = active && isTref && caEn && (caPeriod != '0);
    ctrl.caOn    = modelSel && caEn;
    ctrl.fireOk  = !neurOff;
  end
endmodule

// File: rtl/lif_step_datapath.sv
module lif_step_datapath
  import lif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  step_ctrl_t        ctrl,
  input  logic              evValid,
  input  logic              evInhib,
  input  logic [WT_W-1:0]   evWeight,
  input  logic [WORD_W-1:0] wordIn,
  output logic              outValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              spikeOut,
  output logic              sdspUp,
  output logic              sdspDown
);
  localparam logic [CA_W-1:0] CA_MAX = '1;

  logic [VM_W-1:0]   vCur, thr, thm, leakAmt, wExt;
  logic [VM_W-1:0]   vAdd, vSub, vLeak, vInt, vNext;
  logic [VM_W:0]     sumWide;
  logic [CA_W-1:0]   caCur, ct1, ct2, ct3, caNext;
  logic [CNT_W-1:0]  cntCur, per, cntNext;
  logic [CNT_W:0]    cntInc;
  logic              fire, upNext, dnNext, caInBand;
  logic [WORD_W-1:0] wordNext;

  // membrane path
  always_comb begin
    vCur    = wordIn[VM_LSB +: VM_W];
    thr     = wordIn[THR_LSB +: VM_W];
    leakAmt = {{(VM_W-LEAK_W){1'b0}}, wordIn[LEAK_LSB +: LEAK_W]};
    wExt    = {{(VM_W-WT_W){1'b0}}, evWeight};
    sumWide = {1'b0, vCur} + {1'b0, wExt};
    vAdd    = sumWide[VM_W] ? '1 : sumWide[VM_W-1:0];
    vSub    = (vCur >= wExt) ? (vCur - wExt) : '0;
    vLeak   = (vCur >= leakAmt) ? (vCur - leakAmt) : '0;
    if (ctrl.integ)        vInt = evInhib ? vSub : vAdd;
    else if (ctrl.leakMem) vInt = vLeak;
    else                   vInt = vCur;
    fire  = ctrl.integ && ctrl.fireOk && (vInt >= thr);
    vNext = fire ? '0 : vInt;
  end

  // calcium trace and its prescaled leak
  always_comb begin
    caCur   = wordIn[CA_LSB +: CA_W];
    cntCur  = wordIn[CNT_LSB +: CNT_W];
    per     = wordIn[PER_LSB +: CNT_W];
    caNext  = caCur;
    cntNext = cntCur;
    cntInc  = {1'b0, cntCur} + 1'b1;
    if (fire && ctrl.caOn && (caCur != CA_MAX)) caNext = caCur + 1'b1;
    if (ctrl.caTick) begin
      if (cntInc >= {1'b0, per}) begin
        cntNext = '0;
        if (caCur != '0) caNext = caCur - 1'b1;
      end else begin
        cntNext = cntInc[CNT_W-1:0];
      end
    end
  end

  // learning flags from updated state
  always_comb begin
    thm      = wordIn[THM_LSB +: VM_W];
    ct1      = wordIn[CT1_LSB +: CA_W];
    ct2      = wordIn[CT2_LSB +: CA_W];
    ct3      = wordIn[CT3_LSB +: CA_W];
    caInBand = (caNext >= ct1);
    upNext   = ctrl.caOn && (vNext >= thm) && caInBand && (caNext < ct3);
    dnNext   = ctrl.caOn && (vNext <  thm) && caInBand && (caNext < ct2);
  end

  always_comb begin
    wordNext = wordIn;
    wordNext[VM_LSB +: VM_W]   = vNext;
    wordNext[CA_LSB +: CA_W]   = caNext;
    wordNext[CNT_LSB +: CNT_W] = cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wordOut  <= '0;
      spikeOut <= 1'b0;
      sdspUp   <= 1'b0;
      sdspDown <= 1'b0;
    end else if (ctrl.load) begin
      outValid <= 1'b1;
      wordOut  <= wordNext;
      spikeOut <= fire;
      sdspUp   <= upNext;
      sdspDown <= dnNext;
    end else begin
      outValid <= 1'b0;
      spikeOut <= 1'b0;
      sdspUp   <= 1'b0;
      sdspDown <= 1'b0;
    end
  end

  assert_result_follows_event_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(evValid));
  assert_quiet_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(spikeOut || sdspUp || sdspDown));
  assert_params_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (wordOut[VM_LSB-1:0] == $past(wordIn[VM_LSB-1:0]))
             && (wordOut[WORD_W-1:STATE_MSB+1] == $past(wordIn[WORD_W-1:STATE_MSB+1])));
  assert_spike_clears_vmem_R4: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> (wordOut[VM_LSB +: VM_W] == '0));
  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && wordOut[DIS_BIT]) |-> !spikeOut);
  assert_flags_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !wordOut[CAEN_BIT]) |-> !(sdspUp || sdspDown));
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(sdspUp && sdspDown));
  assert_other_model_untouched_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !wordOut[MODEL_BIT]) |-> (wordOut == $past(wordIn)) && !spikeOut);
endmodule

// File: rtl/lif_neuron_step.sv
module lif_neuron_step
  import lif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evKind,
  input  logic              evInhib,
  input  logic [WT_W-1:0]   evWeight,
  input  logic [WORD_W-1:0] wordIn,
  output logic              outValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              spikeOut,
  output logic              sdspUp,
  output logic              sdspDown
);
  step_ctrl_t ctrl;

  lif_step_ctrl uCtrl (
    .evValid  (evValid),
    .evKind   (evKind),
    .modelSel (wordIn[MODEL_BIT]),
    .leakEn   (wordIn[LEAKEN_BIT]),
    .caEn     (wordIn[CAEN_BIT]),
    .neurOff  (wordIn[DIS_BIT]),
    .caPeriod (wordIn[PER_LSB +: CNT_W]),
    .ctrl     (ctrl)
  );

  lif_step_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .evValid  (evValid),
    .evInhib  (evInhib),
    .evWeight (evWeight),
    .wordIn   (wordIn),
    .outValid (outValid),
    .wordOut  (wordOut),
    .spikeOut (spikeOut),
    .sdspUp   (sdspUp),
    .sdspDown (sdspDown)
  );
endmodule

// File: tb/tb_lif_neuron_step.sv
module tb_lif_neuron_step;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         evValid = 1'b0;
  logic         evKind = 1'b0;
  logic         evInhib = 1'b0;
  logic [2:0]   evWeight = '0;
  logic [127:0] wordIn = '0;
  logic         outValid, spikeOut, sdspUp, sdspDown;
  logic [127:0] wordOut;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  lif_neuron_step dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evKind(evKind),
    .evInhib(evInhib), .evWeight(evWeight), .wordIn(wordIn),
    .outValid(outValid), .wordOut(wordOut), .spikeOut(spikeOut),
    .sdspUp(sdspUp), .sdspDown(sdspDown)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       kind;
    logic       inh;
    logic [2:0] w;
    logic       lif;
    logic       dis;
    logic       leakEn;
    logic [6:0] leakStr;
    logic [7:0] thr;
    logic       caEn;
    logic [7:0] thm;
    logic [2:0] t1, t2, t3;
    logic [4:0] per;
    logic [7:0] v;
    logic [2:0] ca;
    logic [4:0] cnt;
    logic [7:0] eV;
    logic [2:0] eCa;
    logic [4:0] eCnt;
    logic       eSpk, eUp, eDn;
  } vec_t;

  localparam int NV = 18;
  // fields: req kind inh w lif dis leakEn leakStr thr caEn thm t1 t2 t3 per v ca cnt | eV eCa eCnt eSpk eUp eDn
  localparam vec_t VECS [NV] = '{
    '{3, 0,0,5, 1,0,1,10,100,1,50,2,4,6,3,  20,0,0,  25,0,0,0,0,0},  // R3 add
    '{3, 0,0,7, 1,1,1,10,255,1,50,2,4,6,3, 253,3,0, 255,3,0,0,1,0},  // R3 sat 255, R5
    '{3, 0,1,6, 1,0,1,10,100,1,50,2,4,6,3,   4,3,0,   0,3,0,0,0,1},  // R3 sat 0
    '{3, 0,1,3, 1,0,1,10,100,1,50,2,4,6,3,  40,5,0,  37,5,0,0,0,0},  // R3 subtract
    '{4, 0,0,4, 1,0,1,10,100,1,50,2,4,6,3,  97,2,0,   0,3,0,1,0,1},  // R4 spike, R7
    '{7, 0,0,3, 1,0,1,10,100,1,50,2,4,6,3,  97,7,0,   0,7,0,1,0,0},  // R7 sat 7, R4 exact
    '{5, 0,0,5, 1,1,1,10,100,1,50,2,4,6,3,  98,1,0, 103,1,0,0,0,0},  // R5 disabled
    '{6, 1,0,0, 1,0,1,10,100,1,50,2,4,6,3,  45,4,0,  35,4,1,0,0,0},  // R6 leak, R8 count
    '{8, 1,0,0, 1,0,1,10,100,1,50,2,4,6,3,   6,3,2,   0,2,0,0,0,1},  // R8 decay, R6 floor
    '{6, 1,0,0, 1,0,0,10,100,1,50,2,4,6,0,  60,5,4,  60,5,4,0,1,0},  // R6 off, R8 period 0
    '{8, 1,0,0, 1,0,1,10,100,1,50,2,4,6,1,  80,0,0,  70,0,0,0,0,0},  // R8 floor 0
    '{9, 0,0,7, 1,0,1,10,100,0,50,2,4,6,3,  95,2,0,   0,2,0,1,0,0},  // R9 stim
    '{9, 1,0,0, 1,0,1,10,100,0,50,2,4,6,3,  30,5,2,  20,5,2,0,0,0},  // R9 tick
    '{12,0,0,7, 0,0,1,10,100,1,50,2,4,6,3,  99,3,1,  99,3,1,0,0,0},  // R12 other model
    '{10,0,0,0, 1,0,1,10,100,1,50,2,4,6,3,  50,5,0,  50,5,0,0,1,0},  // R10 up edge
    '{10,0,0,0, 1,0,1,10,100,1,50,2,4,6,3,  50,6,0,  50,6,0,0,0,0},  // R10 ca at t3
    '{6, 0,0,0, 1,0,1,10,100,1,50,2,4,6,3,  30,1,1,  30,1,1,0,0,0},  // R6 no leak on stim
    '{11,0,0,0, 1,0,1,10,100,1,50,2,4,6,3,  49,2,0,  49,2,0,0,0,1}   // R11 down edge
  };

  function automatic logic [127:0] mkWord(input vec_t x, input bit useExp);
    logic [127:0] r;
    r = '0;
    r[69:40]   = 30'h2AC3_5A96;
    r[126:86]  = 41'h1_5A5A_C3C3_3C;
    r[0]       = x.lif;
    r[7:1]     = x.leakStr;
    r[8]       = x.leakEn;
    r[16:9]    = x.thr;
    r[17]      = x.caEn;
    r[25:18]   = x.thm;
    r[28:26]   = x.t1;
    r[31:29]   = x.t2;
    r[34:32]   = x.t3;
    r[39:35]   = x.per;
    r[77:70]   = useExp ? x.eV   : x.v;
    r[80:78]   = useExp ? x.eCa  : x.ca;
    r[85:81]   = useExp ? x.eCnt : x.cnt;
    r[127]     = x.dis;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(outValid == 1'b0, "R1 reset outValid", {127'd0, outValid}, 128'd0);
    chk(wordOut == '0, "R1 reset wordOut", wordOut, 128'd0);
    chk({spikeOut, sdspUp, sdspDown} == 3'b000, "R1 reset flags",
        {125'd0, spikeOut, sdspUp, sdspDown}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 idle after reset", {127'd0, outValid}, 128'd0);

    for (int i = 0; i < NV; i++) begin
      evValid  = 1'b1;
      evKind   = VECS[i].kind;
      evInhib  = VECS[i].inh;
      evWeight = VECS[i].w;
      wordIn   = mkWord(VECS[i], 1'b0);
      @(negedge clk);
      evValid  = 1'b0;
      wordIn   = '0;
      chk(outValid == 1'b1, $sformatf("R1 valid vec %0d", i), {127'd0, outValid}, 128'd1);
      chk(wordOut == mkWord(VECS[i], 1'b1), $sformatf("R2/R%0d word vec %0d", VECS[i].req, i),
          wordOut, mkWord(VECS[i], 1'b1));
      chk({spikeOut, sdspUp, sdspDown} == {VECS[i].eSpk, VECS[i].eUp, VECS[i].eDn},
          $sformatf("R%0d spike/up/down vec %0d", VECS[i].req, i),
          {125'd0, spikeOut, sdspUp, sdspDown},
          {125'd0, VECS[i].eSpk, VECS[i].eUp, VECS[i].eDn});
    end

    // R1: pulse ends, flags drop, word held
    @(negedge clk);
    chk(outValid == 1'b0, "R1 pulse ends", {127'd0, outValid}, 128'd0);
    chk({spikeOut, sdspUp, sdspDown} == 3'b000, "R1 flags quiet",
        {125'd0, spikeOut, sdspUp, sdspDown}, 128'd0);
    chk(wordOut == mkWord(VECS[NV-1], 1'b1), "R1 word held", wordOut, mkWord(VECS[NV-1], 1'b1));

    // R8: three ticks with period 3 on calcium 4 -> counter 1,2 then clear with calcium 3
    begin
      vec_t s;
      s = VECS[7];
      s.leakEn = 1'b0;
      for (int k = 0; k < 3; k++) begin
        evValid = 1'b1; evKind = 1'b1; evInhib = 1'b0; evWeight = '0;
        wordIn = mkWord(s, 1'b0);
        @(negedge clk);
        evValid = 1'b0;
        s.cnt = wordOut[85:81];
        s.ca  = wordOut[80:78];
      end
      chk(s.cnt == 5'd0 && s.ca == 3'd3, "R8 period-3 chain",
          {120'd0, s.ca, s.cnt}, {120'd0, 3'd3, 5'd0});
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule